// File: doc/BRIEF.md
# Multi-Line Serial Register Access Port

This block is the control-register front end of a four-line transceiver. An external controller reaches it over four pins: a serial clock, an active-low select, a data input and a data output with a separate output-enable. Every access is two bytes long, and each byte is shifted most significant bit first.

The first byte is the command. Its upper nibble names the line and its lower nibble is a function code. The function code picks one of seven registers for that line and sets the direction of the access. For a write, the controller then sends the new register value as the second byte. For a read, the block shifts the selected register back out during the second byte.

The block holds all 28 eight-bit registers (seven per line, four lines) and drives them continuously onto a flat bus for the line datapaths. The serial pins are oversampled in the system clock domain through a short synchronizer. Each serial clock edge is acted on a few system cycles after it occurs.

Top module: `ctl_port`

## Requirements
- R1: After reset, every bit of all 28 registers on `regs_o` is 0 and `ser_dout_oe` is low.
- R2: The command byte is bit 7 first. Bits 7:4 are the line number (binary) and bits 3:0 are the function code. Codes 0/1 address the transmit D-slot register (index 0), 2/3 transmit B1 (1), 4/5 transmit B2 (2), 6/7 receive D-slot (3), 8/9 receive B1 (4), A/B receive B2 (5) and E/F line control (6). An even code writes and an odd code reads.
- R3: On a write, the second byte (bit 7 first) is stored in the addressed register only once all 8 of its bits have been sampled. No other register changes.
- R4: On a read, the addressed register is shifted out on `ser_dout` bit 7 first. Each bit changes after a falling serial clock edge, so it is valid at the following rising edge. A read changes no register.
- R5: `ser_dout_oe` is high only while the second byte of a valid read is being shifted out: from the falling edge after the 8th rising edge until the falling edge after the 16th.
- R6: A command whose function code is C or D, or whose line nibble is 4 or more, is ignored. No register changes and `ser_dout_oe` stays low.
- R7: Raising `ser_cs_n` aborts a partial access without effect. The next access after select is lowered again starts from bit 0.
- R8: Bits clocked after the 16th rising edge, while select stays low, are ignored. They neither alter the stored value nor enable the output.
- R9: Register index k of line n appears on `regs_o[(n*7+k)*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; idles low; data sampled on rising edges |
| ser_cs_n | input | 1 | Active-low access frame select |
| ser_din | input | 1 | Serial data in, bit 7 of each byte first |
| ser_dout | output | 1 | Serial read data out |
| ser_dout_oe | output | 1 | Drive enable for the serial output pad; pad floats when low |
| regs_o | output | 224 | All register contents, seven bytes per line, line 0 lowest |

## Verification
The assertions assume that the serial clock is far slower than `clk`, with each of its levels held for more than the synchronizer depth plus one cycle. They also assume that `ser_din` is settled before each rising edge and that `ser_cs_n` moves only while the serial clock is low. The bench keeps every serial level for six system cycles and changes data and select only in the low phase. It also holds reset until the pins are idle, so every edge the block sees is a clean, synchronized one.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

  localparam int BYTE_W        = 8;
  localparam int REGS_PER_LINE = 7;

  typedef enum logic [2:0] {
    RS_XMIT_D  = 3'd0,
    RS_XMIT_B1 = 3'd1,
    RS_XMIT_B2 = 3'd2,
    RS_RECV_D  = 3'd3,
    RS_RECV_B1 = 3'd4,
    RS_RECV_B2 = 3'd5,
    RS_LINECTL = 3'd6,
    RS_NONE    = 3'd7
  } reg_sel_e;

  // Function code bits 3:1 choose the register; bit 0 is the direction.
  function automatic reg_sel_e code_to_sel(input logic [3:0] fcode);
    case (fcode[3:1])
      3'd0:    return RS_XMIT_D;
      3'd1:    return RS_XMIT_B1;
      3'd2:    return RS_XMIT_B2;
      3'd3:    return RS_RECV_D;
      3'd4:    return RS_RECV_B1;
      3'd5:    return RS_RECV_B2;
      3'd7:    return RS_LINECTL;
      default: return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_cs_n,
  input  logic ser_din,
  output logic clk_rise,
  output logic clk_fall,
  output logic selected,
  output logic din_s
);
  logic [STAGES:0]   ck_pipe;
  logic [STAGES-1:0] cs_pipe;
  logic [STAGES-1:0] di_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_pipe <= '0;
      cs_pipe <= '1;
      di_pipe <= '0;
    end else begin
      ck_pipe <= {ck_pipe[STAGES-1:0], ser_clk};
      cs_pipe <= {cs_pipe[STAGES-2:0], ser_cs_n};
      di_pipe <= {di_pipe[STAGES-2:0], ser_din};
    end
  end

  assign clk_rise = ck_pipe[STAGES-1] & ~ck_pipe[STAGES];
  assign clk_fall = ~ck_pipe[STAGES-1] & ck_pipe[STAGES];
  assign selected = ~cs_pipe[STAGES-1];
  assign din_s    = di_pipe[STAGES-1];
endmodule

// File: rtl/ctl_shift.sv
module ctl_shift
  import ctl_port_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_rise,
  input  logic              clk_fall,
  input  logic              selected,
  input  logic              din_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [3:0]        cmd_line,
  output reg_sel_e          cmd_sel,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [4:0]        bit_cnt,
  output logic              dout,
  output logic              dout_oe
);
  localparam logic [4:0] CMD_LAST  = 5'd7;
  localparam logic [4:0] DATA_LAST = 5'd15;
  localparam logic [4:0] DONE      = 5'd16;

  logic [BYTE_W-2:0] shreg;
  logic              cmd_ok;
  logic              cmd_rd;
  logic [BYTE_W-1:0] cur_byte;
  logic              in_rd_byte;

  assign cur_byte   = {shreg, din_s};
  assign in_rd_byte = cmd_ok && cmd_rd && (bit_cnt >= 5'd8) && (bit_cnt < DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      cmd_line <= '0;
      cmd_sel  <= RS_NONE;
      cmd_ok   <= 1'b0;
      cmd_rd   <= 1'b0;
      dout     <= 1'b0;
      dout_oe  <= 1'b0;
    end else if (!selected) begin
      bit_cnt <= '0;
      cmd_ok  <= 1'b0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      if (clk_rise && bit_cnt != DONE) begin
        shreg   <= cur_byte[BYTE_W-2:0];
        bit_cnt <= bit_cnt + 5'd1;
        if (bit_cnt == CMD_LAST) begin
          cmd_line <= cur_byte[7:4];
          cmd_sel  <= code_to_sel(cur_byte[3:0]);
          cmd_rd   <= cur_byte[0];
          cmd_ok   <= ({1'b0, cur_byte[7:4]} < 5'(NUM_LINES)) &&
                      (code_to_sel(cur_byte[3:0]) != RS_NONE);
        end
      end
      if (clk_fall) begin
        dout_oe <= in_rd_byte;
        dout    <= in_rd_byte ? rd_data[3'd7 - bit_cnt[2:0]] : 1'b0;
      end
    end
  end

  assign wr_en   = selected && clk_rise && (bit_cnt == DATA_LAST) && cmd_ok && !cmd_rd;
  assign wr_data = cur_byte;
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_port_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_en,
  input  logic [3:0]                              line,
  input  reg_sel_e                                sel,
  input  logic [BYTE_W-1:0]                       wr_data,
  output logic [BYTE_W-1:0]                       rd_data,
  output logic [NUM_LINES*REGS_PER_LINE-1:0]      strobes,
  output logic [NUM_LINES*REGS_PER_LINE*BYTE_W-1:0] regs_flat
);
  localparam int TOTAL = NUM_LINES * REGS_PER_LINE;

  logic [BYTE_W-1:0] mem [TOTAL];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    for (genvar r = 0; r < REGS_PER_LINE; r++) begin : g_reg
      localparam int IDX = l * REGS_PER_LINE + r;
      assign strobes[IDX] = wr_en && (line == 4'(l)) && (sel == reg_sel_e'(3'(r)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            mem[IDX] <= '0;
        else if (strobes[IDX]) mem[IDX] <= wr_data;
      end
      assign regs_flat[IDX*BYTE_W +: BYTE_W] = mem[IDX];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < TOTAL; i++) begin
      if ({1'b0, line} == 5'(i / REGS_PER_LINE) && sel == reg_sel_e'(3'(i % REGS_PER_LINE)))
        rd_data = mem[i];
    end
  end
endmodule

// File: rtl/ctl_port.sv
module ctl_port
  import ctl_port_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      ser_clk,
  input  logic                                      ser_cs_n,
  input  logic                                      ser_din,
  output logic                                      ser_dout,
  output logic                                      ser_dout_oe,
  output logic [NUM_LINES*REGS_PER_LINE*BYTE_W-1:0] regs_o
);
  localparam int TOTAL = NUM_LINES * REGS_PER_LINE;

  logic              clk_rise, clk_fall, sel_s, din_s;
  logic [3:0]        cmd_line;
  reg_sel_e          cmd_sel;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [4:0]        bit_cnt;
  logic [TOTAL-1:0]  wr_strobe;

  ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
    .ser_din(ser_din), .clk_rise(clk_rise), .clk_fall(clk_fall),
    .selected(sel_s), .din_s(din_s)
  );

  ctl_shift #(.NUM_LINES(NUM_LINES)) u_shift (
    .clk(clk), .rst_n(rst_n), .clk_rise(clk_rise), .clk_fall(clk_fall),
    .selected(sel_s), .din_s(din_s), .rd_data(rd_data),
    .cmd_line(cmd_line), .cmd_sel(cmd_sel), .wr_en(wr_en), .wr_data(wr_data),
    .bit_cnt(bit_cnt), .dout(ser_dout), .dout_oe(ser_dout_oe)
  );

  ctl_regbank #(.NUM_LINES(NUM_LINES)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .line(cmd_line), .sel(cmd_sel),
    .wr_data(wr_data), .rd_data(rd_data), .strobes(wr_strobe), .regs_flat(regs_o)
  );
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk #(
  parameter int NUM_LINES = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sel_s,
  input logic [4:0]                   bit_cnt,
  input logic                         wr_en,
  input logic [NUM_LINES*7-1:0]       wr_strobe,
  input logic [NUM_LINES*7*8-1:0]     regs_o,
  input logic                         ser_dout_oe
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) $rose(rst_n) |-> (regs_o == '0 && !ser_dout_oe));

  // R5
  oe_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n) !sel_s |=> !ser_dout_oe);

  // R5
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ser_dout_oe) |-> bit_cnt == 5'd8);

  // R3
  wr_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> bit_cnt == 5'd15);

  // R3
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(regs_o));

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_strobe));
endmodule

bind ctl_port ctl_port_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .bit_cnt(bit_cnt), .wr_en(wr_en),
  .wr_strobe(wr_strobe), .regs_o(regs_o), .ser_dout_oe(ser_dout_oe)
);

// File: tb/test_ctl_port.sv
module test_ctl_port;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_cs_n = 1'b1, ser_din = 1'b0;
  logic ser_dout, ser_dout_oe;
  logic [223:0] regs_o;

  int checks = 0, errors = 0;
  logic [7:0] model [4][7];
  logic [7:0] exp_q[$];
  bit rd_window = 1'b0;
  logic [7:0] rbits;
  int rn = 0;

  always #2 clk = ~clk;

  ctl_port i_ctl_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe), .regs_o(regs_o)
  );

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input int idx, input bit rd);
    logic [3:0] c;
    c = (idx == 6) ? 4'hE : 4'(idx * 2);
    return c | {3'b0, rd};
  endfunction

  task automatic check_regs(input string req);
    logic [223:0] e;
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 7; k++)
        e[(l*7+k)*8 +: 8] = model[l][k];
    check(regs_o === e, req, {32'b0, regs_o}, {32'b0, e});
  endtask

  // Driver: shifts nbits (cmd then data, then 1s); pushes expected read byte.
  task automatic access(input logic [7:0] cmd, input logic [7:0] data, input int nbits,
                        input bit rd_en, input logic [7:0] exp_rd);
    if (rd_en) exp_q.push_back(exp_rd);
    @(negedge clk); ser_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_clk = 1'b0;
      if (i < 8)       ser_din = cmd[7-i];
      else if (i < 16) ser_din = data[15-i];
      else             ser_din = 1'b1;
      if (i == 8)  rd_window = rd_en;
      if (i == 16) rd_window = 1'b0;
      repeat (H) @(negedge clk);
      ser_clk = 1'b1;
      repeat (H) @(negedge clk);
    end
    ser_clk = 1'b0;
    rd_window = 1'b0;
    repeat (H) @(negedge clk);
    ser_cs_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  // Monitor: at each serial rising edge compare the output enable, collect read bits.
  always @(posedge ser_clk) begin
    check(ser_dout_oe === rd_window, "R5 oe window", {255'b0, ser_dout_oe}, {255'b0, rd_window});
    if (rd_window) begin
      rbits = {rbits[6:0], ser_dout};
      rn++;
      if (rn == 8) begin
        rn = 0;
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected read", {248'b0, rbits}, 256'b0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rbits === e, "R4 read data", {248'b0, rbits}, {248'b0, e});
        end
      end
    end
  end

  always @(posedge ser_cs_n) rn = 0;

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 7; k++)
        model[l][k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(regs_o === '0, "R1 regs zero", {32'b0, regs_o}, 256'b0);
    check(ser_dout_oe === 1'b0, "R1 oe low", {255'b0, ser_dout_oe}, 256'b0);

    // R2 R3 R9 write every register of every line
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 7; k++) begin
        logic [7:0] v;
        v = {2'(l), 3'(k), 3'b101} ^ 8'h96;
        access({4'(l), code_of(k, 1'b0)}, v, 16, 1'b0, 8'h00);
        model[l][k] = v;
        check_regs("R3 R9 write map");
      end

    // R2 R4 read every register back
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 7; k++)
        access({4'(l), code_of(k, 1'b1)}, 8'h00, 16, 1'b1, model[l][k]);
    check_regs("R4 read leaves registers");

    // R2 bit order: single-bit patterns at both ends
    access({4'd2, code_of(6, 1'b0)}, 8'h80, 16, 1'b0, 8'h00); model[2][6] = 8'h80;
    check_regs("R2 msb first write");
    access({4'd2, code_of(6, 1'b1)}, 8'h00, 16, 1'b1, 8'h80);
    access({4'd1, code_of(0, 1'b0)}, 8'h01, 16, 1'b0, 8'h00); model[1][0] = 8'h01;
    check_regs("R2 lsb last write");
    access({4'd1, code_of(0, 1'b1)}, 8'h00, 16, 1'b1, 8'h01);

    // R6 unused codes C/D and out-of-range lines
    access({4'd0, 4'hC}, 8'h5A, 16, 1'b0, 8'h00);
    check_regs("R6 code C ignored");
    access({4'd3, 4'hD}, 8'h00, 16, 1'b0, 8'h00);
    check_regs("R6 code D ignored");
    access({4'd4, code_of(1, 1'b0)}, 8'h3C, 16, 1'b0, 8'h00);
    check_regs("R6 line 4 ignored");
    access({4'd15, code_of(6, 1'b1)}, 8'h00, 16, 1'b0, 8'h00);
    check_regs("R6 line 15 read ignored");

    // R7 abort after 15 bits, then a clean access
    access({4'd3, code_of(5, 1'b0)}, 8'hFF, 15, 1'b0, 8'h00);
    check_regs("R7 R3 abort no write");
    access({4'd3, code_of(5, 1'b0)}, 8'h42, 16, 1'b0, 8'h00); model[3][5] = 8'h42;
    check_regs("R7 access after abort");
    access({4'd3, code_of(5, 1'b1)}, 8'h00, 16, 1'b1, 8'h42);

    // R8 trailing bits ignored on write and read
    access({4'd0, code_of(3, 1'b0)}, 8'h24, 24, 1'b0, 8'h00); model[0][3] = 8'h24;
    check_regs("R8 trailing bits write");
    access({4'd0, code_of(3, 1'b1)}, 8'h00, 24, 1'b1, 8'h24);
    check_regs("R8 trailing bits read");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4 all reads seen", 256'(exp_q.size()), 256'b0);
    finish_run();
  end
endmodule